// File: doc/BRIEF.md
# Charge-Pump Pulse Lock Detector

This block decides whether a phase-locked loop is locked by watching the two charge-pump drive pulses, pump-up and pump-down. It runs on the crystal clock. While the loop is in lock, the phase error is tiny and each pump pulse lasts well under one crystal period. A pulse that covers two or more crystal clock samples therefore means the loop has lost phase. The block clears its lock flag as soon as it sees one such pulse.

Setting the flag again is slower on purpose. A strobe marks the end of each reference period. The flag is raised only after eight strobes in a row, each ending a period in which no pump pulse was wide. Fast clearing and slow setting give an asymmetric hysteresis. A single clean period in a bad run cannot report lock, and one bad pulse is never missed.

The pump inputs come straight from the phase detector and are asynchronous to the crystal clock. They pass through a two-flop synchronizer before they are measured. The reference strobe is a one-cycle pulse that is already synchronous to the crystal clock.

Top module: `pump_lock_detector`

## Requirements
- R1: While `rst` is high and after it is released, `lock_flag` is 0 until lock is earned as in R5.
- R2: A high level on `pump_up` sampled at two or more consecutive rising clock edges is a wide pulse. If the first of those edges is edge 0, `lock_flag` is still 1 after edge 3 and is 0 after edge 4.
- R3: A wide pulse on `pump_dn`, with the same definition and the same timing as R2, also clears `lock_flag`. A long pulse keeps the flag at 0.
- R4: A pulse on `pump_up`, on `pump_dn`, or on both together that is sampled high at only one edge is narrow. A narrow pulse never clears `lock_flag`, and its period still counts as clean.
- R5: A period is clean if no wide pulse occurred since the previous `ref_tick`. With `lock_flag` at 0, the flag becomes 1 right after the edge that samples the eighth consecutive `ref_tick` ending a clean period. After the seventh such tick the flag is still 0.
- R6: A wide pulse restarts the clean-period run from zero. The tick that ends the period holding the wide pulse does not count. Eight more clean ticks are then needed.
- R7: Once `lock_flag` is 1, it stays 1 across any number of reference periods that contain only narrow pulses or no pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal clock; every register uses its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle strobe at the end of each reference period, synchronous to `clk` |
| pump_up | input | 1 | Pump-up pulse from the phase detector, asynchronous |
| pump_dn | input | 1 | Pump-down pulse from the phase detector, asynchronous |
| lock_flag | output | 1 | 1 while the loop is judged locked |

## Verification
The clearing latency is exact. There are two synchronizer flops, one width-counter cycle and the registered wide event, so the flag falls after the fourth edge following the first sampled high pump level. The bench checks that the flag is still high after the third edge and low after the fourth. The setting latency is one edge after a qualifying `ref_tick`, so the bench reads the flag on the falling edge right after each tick's rising edge: low after the seventh clean tick, high after the eighth. All inputs change on falling edges and all samples are taken there, so no check depends on the order of processes at the active edge.

// File: rtl/plock_pkg.sv
package plock_pkg;

    // Default build choices for the lock detector.
    localparam int unsigned PL_SYNC_STAGES = 2;
    localparam int unsigned PL_WIDE_LIMIT  = 2;   // clocks high that make a pulse wide
    localparam int unsigned PL_GOOD_RUN    = 8;   // clean periods needed to lock

    // The two pump drive lines travel together through the synchronizer.
    typedef struct packed {
        logic up;
        logic dn;
    } pump_pair_t;

    localparam int unsigned PUMP_PAIR_W = $bits(pump_pair_t);

    // Width of a counter that must hold values 0..max_val.
    function automatic int unsigned count_bits(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

    // True when either pump line is driving.
    function automatic logic pump_active(input pump_pair_t p);
        return p.up | p.dn;
    endfunction

endpackage

// File: rtl/plock_sync.sv
module plock_sync #(
    parameter int unsigned STAGES = plock_pkg::PL_SYNC_STAGES,
    parameter int unsigned WIDTH  = plock_pkg::PUMP_PAIR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= '0;
                    else     chain_q[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= '0;
                    else     chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/plock_width_meter.sv
module plock_width_meter #(
    parameter int unsigned WIDE_LIMIT = plock_pkg::PL_WIDE_LIMIT
) (
    input  logic                   clk,
    input  logic                   rst,
    input  plock_pkg::pump_pair_t  pump_s,
    output logic                   wide_hit
);

    localparam int unsigned CW = plock_pkg::count_bits(WIDE_LIMIT);
    localparam logic [CW-1:0] CNT_MAX  = CW'(WIDE_LIMIT);
    localparam logic [CW-1:0] CNT_EDGE = CW'(WIDE_LIMIT - 1);

    logic          active;
    logic [CW-1:0] high_cnt;

    assign active = plock_pkg::pump_active(pump_s);

    // Count crystal clocks with a pump line high; saturate at the limit.
    always_ff @(posedge clk) begin
        if (rst) begin
            high_cnt <= '0;
        end else if (!active) begin
            high_cnt <= '0;
        end else if (high_cnt != CNT_MAX) begin
            high_cnt <= high_cnt + 1'b1;
        end
    end

    // One registered event per pulse, when its width first reaches the limit.
    always_ff @(posedge clk) begin
        if (rst) wide_hit <= 1'b0;
        else     wide_hit <= active && (high_cnt == CNT_EDGE);
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        high_cnt <= CNT_MAX); // R2

    AST_WIDE_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        wide_hit |=> !wide_hit); // R3

    AST_IDLE_NO_WIDE: assert property (@(posedge clk) disable iff (rst)
        !active |=> !wide_hit); // R4

endmodule

// File: rtl/plock_run_tracker.sv
module plock_run_tracker #(
    parameter int unsigned GOOD_RUN = plock_pkg::PL_GOOD_RUN
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_tick,
    input  logic wide_hit,
    output logic lock_flag
);

    localparam int unsigned RW = plock_pkg::count_bits(GOOD_RUN);
    localparam logic [RW-1:0] RUN_FULL = RW'(GOOD_RUN);
    localparam logic [RW-1:0] RUN_LAST = RW'(GOOD_RUN - 1);

    logic [RW-1:0] run_cnt;
    logic          period_dirty;
    logic          tick_clean;

    // The period that this tick closes had no wide pulse.
    assign tick_clean = ref_tick && !period_dirty && !wide_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt      <= '0;
            period_dirty <= 1'b0;
        end else if (ref_tick) begin
            period_dirty <= 1'b0;
            if (!tick_clean)          run_cnt <= '0;
            else if (run_cnt != RUN_FULL) run_cnt <= run_cnt + 1'b1;
        end else if (wide_hit) begin
            period_dirty <= 1'b1;
            run_cnt      <= '0;
        end
    end

    // Fast clear on any wide pulse, slow set after a full clean run.
    always_ff @(posedge clk) begin
        if (rst)                                   lock_flag <= 1'b0;
        else if (wide_hit)                         lock_flag <= 1'b0;
        else if (tick_clean && run_cnt == RUN_LAST) lock_flag <= 1'b1;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> !lock_flag); // R1

    AST_WIDE_DROPS_LOCK: assert property (@(posedge clk) disable iff (rst)
        wide_hit |=> !lock_flag); // R2

    AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_flag) |-> $past(ref_tick)); // R5

    AST_RISE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_flag) |-> ($past(run_cnt) == RUN_LAST)); // R5

    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= RUN_FULL); // R6

    AST_DIRTY_ZEROES_RUN: assert property (@(posedge clk) disable iff (rst)
        (ref_tick && period_dirty) |=> (run_cnt == '0)); // R6

    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (lock_flag && !wide_hit) |=> lock_flag); // R7

endmodule

// File: rtl/pump_lock_detector.sv
module pump_lock_detector #(
    parameter int unsigned SYNC_STAGES = plock_pkg::PL_SYNC_STAGES,
    parameter int unsigned WIDE_LIMIT  = plock_pkg::PL_WIDE_LIMIT,
    parameter int unsigned GOOD_RUN    = plock_pkg::PL_GOOD_RUN
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_tick,
    input  logic pump_up,
    input  logic pump_dn,
    output logic lock_flag
);

    import plock_pkg::*;

    pump_pair_t pump_raw;
    pump_pair_t pump_s;
    logic       wide_hit;

    assign pump_raw.up = pump_up;
    assign pump_raw.dn = pump_dn;

    plock_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (PUMP_PAIR_W)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pump_raw),
        .sync_out (pump_s)
    );

    plock_width_meter #(
        .WIDE_LIMIT (WIDE_LIMIT)
    ) u_meter (
        .clk      (clk),
        .rst      (rst),
        .pump_s   (pump_s),
        .wide_hit (wide_hit)
    );

    plock_run_tracker #(
        .GOOD_RUN (GOOD_RUN)
    ) u_tracker (
        .clk       (clk),
        .rst       (rst),
        .ref_tick  (ref_tick),
        .wide_hit  (wide_hit),
        .lock_flag (lock_flag)
    );

endmodule

// File: tb/tb_pump_lock_detector.sv
module tb_pump_lock_detector;

    localparam int PERIOD_CYC = 16;

    // Pulse kinds used inside a reference period.
    localparam int K_NONE   = 0;
    localparam int K_N_UP   = 1;
    localparam int K_N_DN   = 2;
    localparam int K_N_BOTH = 3;
    localparam int K_W_UP   = 4;
    localparam int K_W_DN   = 5;

    logic clk = 1'b0;
    logic rst;
    logic ref_tick;
    logic pump_up;
    logic pump_dn;
    logic lock_flag;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    pump_lock_detector dut (
        .clk       (clk),
        .rst       (rst),
        .ref_tick  (ref_tick),
        .pump_up   (pump_up),
        .pump_dn   (pump_dn),
        .lock_flag (lock_flag)
    );

    task automatic check(input logic actual, input logic expected, input string tag);
        total++;
        if (actual !== expected) begin
            bad++;
            $display("FAIL %s: lock_flag=%0b expected=%0b", tag, actual, expected);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One reference period: a pulse of the given kind, then the closing tick.
    // Returns on the falling edge right after the tick's rising edge.
    task automatic period(input int kind);
        idle(4);
        case (kind)
            K_N_UP:   pump_up = 1'b1;
            K_N_DN:   pump_dn = 1'b1;
            K_N_BOTH: begin pump_up = 1'b1; pump_dn = 1'b1; end
            K_W_UP:   pump_up = 1'b1;
            K_W_DN:   pump_dn = 1'b1;
            default:  ;
        endcase
        idle((kind >= K_W_UP) ? 3 : 1);
        pump_up = 1'b0;
        pump_dn = 1'b0;
        idle(PERIOD_CYC - 9);
        ref_tick = 1'b1;
        @(negedge clk);
        ref_tick = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; ref_tick = 1'b0; pump_up = 1'b0; pump_dn = 1'b0;
        idle(3);
        check(lock_flag, 1'b0, "R1 during reset");
        rst = 1'b0;
        idle(5);
        check(lock_flag, 1'b0, "R1 after reset");
    endtask

    // Eight clean ticks with mixed narrow pulses: low after 7, high after 8.
    task automatic t_acquire();
        for (int i = 0; i < 7; i++) period(K_N_UP + (i % 3));
        check(lock_flag, 1'b0, "R5 after seven clean ticks");
        period(K_NONE);
        check(lock_flag, 1'b1, "R5 after eighth clean tick");
    endtask

    // Two-clock pulse: flag high after edge 3, low after edge 4.
    task automatic t_lose(input bit use_dn, input string tag);
        idle(2);
        if (use_dn) pump_dn = 1'b1; else pump_up = 1'b1;
        idle(2);
        pump_up = 1'b0; pump_dn = 1'b0;
        idle(2);
        check(lock_flag, 1'b1, {tag, " flag kept before edge 4"});
        idle(1);
        check(lock_flag, 1'b0, {tag, " flag cleared after edge 4"});
        idle(6);
        period(K_NONE);
        check(lock_flag, 1'b0, {tag, " dirty period tick not counted"});
    endtask

    // Narrow pulses of every kind keep lock.
    task automatic t_hold();
        for (int i = 0; i < 6; i++) begin
            period(K_N_UP + (i % 3));
            check(lock_flag, 1'b1, "R4 R7 narrow pulse keeps lock");
        end
        period(K_NONE);
        check(lock_flag, 1'b1, "R7 idle period keeps lock");
    endtask

    // A wide pulse mid-run restarts the count.
    task automatic t_run_restart();
        for (int i = 0; i < 5; i++) period(K_N_DN);
        check(lock_flag, 1'b0, "R6 partial run stays unlocked");
        period(K_W_DN);
        check(lock_flag, 1'b0, "R6 wide period stays unlocked");
        for (int i = 0; i < 7; i++) period(K_N_UP);
        check(lock_flag, 1'b0, "R6 seven after wide not enough");
        period(K_NONE);
        check(lock_flag, 1'b1, "R6 eight after wide locks");
    endtask

    // Long pump-down pulse drops lock and holds it low.
    task automatic t_long_pulse();
        idle(2);
        pump_dn = 1'b1;
        idle(20);
        check(lock_flag, 1'b0, "R3 long pulse keeps flag low");
        pump_dn = 1'b0;
        idle(4);
        check(lock_flag, 1'b0, "R3 flag low after long pulse");
    endtask

    initial begin
        do_reset();
        t_acquire();
        t_lose(1'b0, "R2 pump_up");
        t_acquire();
        t_hold();
        t_lose(1'b1, "R3 pump_dn");
        t_run_restart();
        t_long_pulse();
        period(K_NONE);
        t_acquire();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule